// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block collects 64 interrupt request lines into two banks of 32 bits each. It reports a single combined interrupt to the processor. Each bank keeps four pieces of state. Latched events record rising edges on lines that work in edge mode. Live levels mirror the sampled inputs. An enable mask selects which sources may reach the processor. A fixed per-bit mode vector marks some lines as level sources, and for those lines the live level counts directly and nothing is latched.

Software reaches the banks over a simple 32-bit register bus. It reads events, mask and levels, and writes the mask. It clears latched events by writing ones to an acknowledge register. Level-mode bits cannot be cleared this way. They drop only when their input line falls. The processor interrupt is the OR over both banks of the enabled pending bits. A pending bit is set when the bit's event is latched, or when the line is in level mode and its level is high.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset all events, masks and levels are zero, `cpuIrq` is 0 and `busRdata` is 0.
- R2: Address bits [11:4] pick the bank: value 1 selects bank 0 (0x10–0x1F) and value 2 selects bank 1 (0x20–0x2F). Any other value makes a read return 0 and a write change nothing.
- R3: Inside a bank, address bits [3:0] pick the register. 0x0 reads events. 0x4 reads and writes the mask. 0x8 is the acknowledge register: it is write-only and reads as 0. 0xC reads levels. Any other offset reads 0 and ignores writes, and the events and levels registers cannot be written.
- R4: Line n (0–31) is bit n of bank 1. Line n (32–63) is bit n−32 of bank 0.
- R5: A rising input sets its levels bit, and also sets its events bit when the bit is in edge mode. A falling input clears only its levels bit, so a latched event stays set. A line held high does not latch again after it has been acknowledged.
- R6: Bits 20 to 28 of bank 1 are in level mode, and every bit of bank 0 is in edge mode. A level-mode bit never latches an event. It is pending while its line is high and the bit is unmasked, and an acknowledge write has no effect on it.
- R7: Writing to the acknowledge register clears every edge-mode events bit that is 1 in the written data.
- R8: When a rising edge and an acknowledge of the same bit fall in the same cycle, the events bit stays set.
- R9: `cpuIrq` is 1 exactly when either bank has a nonzero (events | (levels & mode)) & mask. It follows the state with one cycle of latency.
- R10: Read data appears on `busRdata` one cycle after the cycle in which `busRe` is high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 12 | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| irqIn | input | 64 | Interrupt request lines |
| cpuIrq | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach is a rising edge and an acknowledge landing on the same bit in the same clock. The bench first latches and releases line 5. It then raises line 5 again and issues the acknowledge write on the same falling clock edge, so that both are sampled by one rising edge. A second hard area is showing that a write was ignored. After every write to an invalid bank or offset, the bench reads back the registers that a faulty decode would have changed. Those registers are preloaded with values that differ from what a wrong hit would leave.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int OFF_W      = 4;
  localparam int BANK_IDX_W = 8;

  localparam logic [OFF_W-1:0] OFF_EVENTS = 4'h0;
  localparam logic [OFF_W-1:0] OFF_MASK   = 4'h4;
  localparam logic [OFF_W-1:0] OFF_ACK    = 4'h8;
  localparam logic [OFF_W-1:0] OFF_LEVELS = 4'hC;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_EVENTS,
    SRC_MASK,
    SRC_LEVELS
  } rdSrc_e;

  typedef struct packed {
    logic [BANK_IDX_W-1:0] bankIdx;
    logic                  maskWr;
    logic                  ackWr;
    logic                  rdEn;
    rdSrc_e                rdSrc;
  } ctrlStrobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 2,
  parameter int BASE_SLOT = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output ctrlStrobes_t      strobes
);
  localparam int SLOT_W = ADDR_W - OFF_W;

  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  offs;
  logic              bankHit;

  assign slot = busAddr[ADDR_W-1:OFF_W];
  assign offs = busAddr[OFF_W-1:0];

  // Only slots BASE_SLOT .. BASE_SLOT+NUM_BANKS-1 address a bank
  assign bankHit = (slot >= SLOT_W'(BASE_SLOT)) &&
                   (slot <  SLOT_W'(BASE_SLOT + NUM_BANKS));

  always_comb begin
    strobes.bankIdx = BANK_IDX_W'(slot - SLOT_W'(BASE_SLOT));
    strobes.maskWr  = 1'b0;
    strobes.ackWr   = 1'b0;
    strobes.rdEn    = busRe;
    strobes.rdSrc   = SRC_NONE;
    if (bankHit) begin
      case (offs)
        OFF_EVENTS: strobes.rdSrc = SRC_EVENTS;
        OFF_MASK: begin
          strobes.rdSrc  = SRC_MASK;
          strobes.maskWr = busWe;
        end
        OFF_ACK:    strobes.ackWr = busWe;
        OFF_LEVELS: strobes.rdSrc = SRC_LEVELS;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int               BANK_W   = 32,
  parameter logic [BANK_W-1:0] LVL_MODE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] lineIn,
  input  logic              maskWr,
  input  logic              ackWr,
  input  logic [BANK_W-1:0] wrData,
  output logic [BANK_W-1:0] evOut,
  output logic [BANK_W-1:0] maskOut,
  output logic [BANK_W-1:0] lvlOut,
  output logic              pendAny
);
  logic [BANK_W-1:0] riseBits;
  logic [BANK_W-1:0] ackBits;
  logic [BANK_W-1:0] evNext;

  // lvlOut doubles as the previous sample for edge detection
  assign riseBits = lineIn & ~lvlOut;
  assign ackBits  = ackWr ? (wrData & ~LVL_MODE) : '0;
  // set after clear: a new edge beats an acknowledge in the same cycle
  assign evNext   = (evOut & ~ackBits) | (riseBits & ~LVL_MODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evOut   <= '0;
      maskOut <= '0;
      lvlOut  <= '0;
    end else begin
      lvlOut <= lineIn;
      evOut  <= evNext;
      if (maskWr) maskOut <= wrData;
    end
  end

  assign pendAny = |((evOut | (lvlOut & LVL_MODE)) & maskOut);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int                          BANK_W    = 32,
  parameter int                          NUM_BANKS = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LVL_MODE  = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [BANK_W-1:0]           busWdata,
  input  logic [NUM_BANKS*BANK_W-1:0] irqIn,
  output logic [BANK_W-1:0]           busRdata,
  output logic                        cpuIrq,
  output logic [NUM_BANKS*BANK_W-1:0] eventsLine,
  output logic [NUM_BANKS*BANK_W-1:0] levelsLine,
  output logic [NUM_BANKS*BANK_W-1:0] maskLine,
  output logic [NUM_BANKS*BANK_W-1:0] modeLine
);
  logic [BANK_W-1:0]    bankEv   [NUM_BANKS];
  logic [BANK_W-1:0]    bankMask [NUM_BANKS];
  logic [BANK_W-1:0]    bankLvl  [NUM_BANKS];
  logic [NUM_BANKS-1:0] bankPend;
  logic [BANK_W-1:0]    rdMux;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // lower line numbers land in the highest bank
    localparam int LINE_BASE = (NUM_BANKS - 1 - b) * BANK_W;
    logic selHere;
    assign selHere = (strobes.bankIdx == BANK_IDX_W'(b));

    intc_bank #(
      .BANK_W  (BANK_W),
      .LVL_MODE(LVL_MODE[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (irqIn[LINE_BASE +: BANK_W]),
      .maskWr (strobes.maskWr && selHere),
      .ackWr  (strobes.ackWr && selHere),
      .wrData (busWdata),
      .evOut  (bankEv[b]),
      .maskOut(bankMask[b]),
      .lvlOut (bankLvl[b]),
      .pendAny(bankPend[b])
    );

    assign eventsLine[LINE_BASE +: BANK_W] = bankEv[b];
    assign levelsLine[LINE_BASE +: BANK_W] = bankLvl[b];
    assign maskLine[LINE_BASE +: BANK_W]   = bankMask[b];
    assign modeLine[LINE_BASE +: BANK_W]   = LVL_MODE[b*BANK_W +: BANK_W];
  end

  always_comb begin
    rdMux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strobes.bankIdx == BANK_IDX_W'(b)) begin
        case (strobes.rdSrc)
          SRC_EVENTS: rdMux = bankEv[b];
          SRC_MASK:   rdMux = bankMask[b];
          SRC_LEVELS: rdMux = bankLvl[b];
          default:    rdMux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      cpuIrq   <= 1'b0;
    end else begin
      if (strobes.rdEn) busRdata <= rdMux;
      cpuIrq <= |bankPend;
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int                          ADDR_W    = 12,
  parameter int                          BANK_W    = 32,
  parameter int                          NUM_BANKS = 2,
  parameter int                          BASE_SLOT = 1,
  parameter logic [NUM_BANKS*BANK_W-1:0] LVL_MODE  = 64'h1FF00000_00000000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [BANK_W-1:0]           busWdata,
  input  logic                        busRe,
  output logic [BANK_W-1:0]           busRdata,
  input  logic [NUM_BANKS*BANK_W-1:0] irqIn,
  output logic                        cpuIrq
);
  localparam int LINES = NUM_BANKS * BANK_W;

  ctrlStrobes_t     strobes;
  logic [LINES-1:0] eventsLine;
  logic [LINES-1:0] levelsLine;
  logic [LINES-1:0] maskLine;
  logic [LINES-1:0] modeLine;

  intc_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .BASE_SLOT(BASE_SLOT)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .busRe  (busRe),
    .strobes(strobes)
  );

  intc_datapath #(
    .BANK_W   (BANK_W),
    .NUM_BANKS(NUM_BANKS),
    .LVL_MODE (LVL_MODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWdata  (busWdata),
    .irqIn     (irqIn),
    .busRdata  (busRdata),
    .cpuIrq    (cpuIrq),
    .eventsLine(eventsLine),
    .levelsLine(levelsLine),
    .maskLine  (maskLine),
    .modeLine  (modeLine)
  );
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRe,
  input logic [DATA_W-1:0] busRdata,
  input logic [LINES-1:0]  irqIn,
  input logic              cpuIrq,
  input logic [LINES-1:0]  eventsLine,
  input logic [LINES-1:0]  levelsLine,
  input logic [LINES-1:0]  maskLine,
  input logic [LINES-1:0]  modeLine
);
  // R9
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskLine == '0) |=> !cpuIrq);

  // R2
  bad_bank_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr[ADDR_W-1:4] == '0) |=> (busRdata == '0));

  // R3
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr[3:0] == 4'h8) |=> (busRdata == '0));

  // R5
  no_rise_no_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqIn & ~levelsLine) == '0) |=> ((eventsLine & ~$past(eventsLine)) == '0));

  // R6
  level_never_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventsLine & modeLine) == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> $stable(busRdata));
endmodule

bind dual_bank_intc dual_bank_intc_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(BANK_W),
  .LINES (NUM_BANKS * BANK_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRe     (busRe),
  .busRdata  (busRdata),
  .irqIn     (irqIn),
  .cpuIrq    (cpuIrq),
  .eventsLine(eventsLine),
  .levelsLine(levelsLine),
  .maskLine  (maskLine),
  .modeLine  (modeLine)
);

// File: tb/sim_dual_bank_intc.sv
module sim_dual_bank_intc;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic        busWe;
  logic [31:0] busWdata;
  logic        busRe;
  logic [31:0] busRdata;
  logic [63:0] irqIn;
  logic        cpuIrq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } rdItem_t;

  rdItem_t sbQ[$];
  logic    sawRe = 1'b0;

  always #5 clk = ~clk;

  dual_bank_intc u0 (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busWdata(busWdata),
    .busRe   (busRe),
    .busRdata(busRdata),
    .irqIn   (irqIn),
    .cpuIrq  (cpuIrq)
  );

  // monitor: a read strobe seen at a rising edge yields data by the next falling edge
  always @(posedge clk) sawRe <= busRe;

  always @(negedge clk) begin
    rdItem_t it;
    if (sawRe) begin
      checks++;
      if (sbQ.size() == 0) begin
        errors++;
        $display("FAIL %s read with empty scoreboard actual=%h expected=none", "R10", busRdata);
      end else begin
        it = sbQ.pop_front();
        if (busRdata !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdata, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    rdItem_t it;
    @(negedge clk);
    busAddr = a;
    busRe   = 1'b1;
    it.addr = a; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic setLines(input logic [63:0] v);
    @(negedge clk);
    irqIn = v;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    checks++;
    if (cpuIrq !== e) begin
      errors++;
      $display("FAIL %s cpuIrq actual=%b expected=%b", tag, cpuIrq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWe = 1'b0; busWdata = '0; busRe = 1'b0; irqIn = '0;
    tick(3);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1");
    rd(12'h010, 32'h0, "R1");
    rd(12'h014, 32'h0, "R1");
    rd(12'h02C, 32'h0, "R1");
    rd(12'h020, 32'h0, "R1");

    // R4 R5: line 3 lands in bank 1 bit 3
    setLines(64'h8);
    rd(12'h020, 32'h8, "R4");
    rd(12'h010, 32'h0, "R4");
    rd(12'h02C, 32'h8, "R5");
    checkIrq(1'b0, "R9");

    // R3 mask read-back, R9 unmasking raises the interrupt
    wr(12'h024, 32'h8);
    rd(12'h024, 32'h8, "R3");
    checkIrq(1'b1, "R9");

    // R5 falling line keeps the event
    setLines(64'h0);
    rd(12'h02C, 32'h0, "R5");
    rd(12'h020, 32'h8, "R5");
    checkIrq(1'b1, "R5");

    // R7 acknowledge clears
    wr(12'h028, 32'h8);
    rd(12'h020, 32'h0, "R7");
    checkIrq(1'b0, "R7");

    // R5 held line does not relatch after acknowledge
    setLines(64'h8);
    tick(3);
    rd(12'h020, 32'h8, "R5");
    wr(12'h028, 32'h8);
    tick(4);
    rd(12'h020, 32'h0, "R5");
    checkIrq(1'b0, "R5");
    setLines(64'h0);

    // R4 line 40 lands in bank 0 bit 8
    setLines(64'h1 << 40);
    rd(12'h010, 32'h100, "R4");
    rd(12'h020, 32'h0, "R4");
    wr(12'h014, 32'h100);
    tick(1);
    checkIrq(1'b1, "R9");
    wr(12'h018, 32'h100);
    tick(1);
    checkIrq(1'b0, "R7");
    setLines(64'h0);

    // R6 level-mode bit of bank 1 (line 20)
    setLines(64'h1 << 20);
    rd(12'h020, 32'h0, "R6");
    rd(12'h02C, 32'h0010_0000, "R6");
    checkIrq(1'b0, "R9");
    wr(12'h024, 32'h0010_0000);
    tick(1);
    checkIrq(1'b1, "R6");
    wr(12'h028, 32'hFFFF_FFFF);
    tick(1);
    checkIrq(1'b1, "R6");
    rd(12'h020, 32'h0, "R6");
    setLines(64'h0);
    tick(2);
    checkIrq(1'b0, "R6");
    // R6 bank 0 bit 20 (line 52) is edge mode
    setLines(64'h1 << 52);
    setLines(64'h0);
    rd(12'h010, 32'h0010_0000, "R6");
    wr(12'h018, 32'h0010_0000);

    // R2 invalid banks: reads 0, writes ignored
    setLines(64'h1 << 40);
    setLines(64'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h114, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h038, 32'hFFFF_FFFF);
    rd(12'h014, 32'h100, "R2");
    rd(12'h024, 32'h0010_0000, "R2");
    rd(12'h010, 32'h100, "R2");
    rd(12'h000, 32'h0, "R2");
    rd(12'h004, 32'h0, "R2");
    rd(12'h034, 32'h0, "R2");
    rd(12'hFF4, 32'h0, "R2");
    checkIrq(1'b1, "R2");
    wr(12'h018, 32'h100);
    tick(1);
    checkIrq(1'b0, "R7");

    // R3 offsets
    setLines(64'h1 << 32);
    setLines(64'h0);
    rd(12'h018, 32'h0, "R3");
    rd(12'h011, 32'h0, "R3");
    rd(12'h012, 32'h0, "R3");
    wr(12'h015, 32'hFFFF_FFFF);
    rd(12'h014, 32'h100, "R3");
    wr(12'h019, 32'h1);
    rd(12'h010, 32'h1, "R3");
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, 32'h0, "R3");
    wr(12'h010, 32'h0);
    rd(12'h010, 32'h1, "R3");
    wr(12'h018, 32'h1);
    rd(12'h010, 32'h0, "R7");

    // R8 new edge wins over same-cycle acknowledge
    setLines(64'h20);
    setLines(64'h0);
    @(negedge clk);
    irqIn    = 64'h20;
    busAddr  = 12'h028;
    busWdata = 32'h20;
    busWe    = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    rd(12'h020, 32'h20, "R8");
    setLines(64'h0);
    wr(12'h028, 32'h20);
    rd(12'h020, 32'h0, "R8");

    // R10 data holds between reads
    rd(12'h014, 32'h100, "R10");
    tick(3);
    checks++;
    if (busRdata !== 32'h100) begin
      errors++;
      $display("FAIL R10 hold actual=%h expected=%h", busRdata, 32'h100);
    end

    tick(2);
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL R10 unanswered reads actual=%0d expected=0", sbQ.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule